// File: doc/BRIEF.md
# Blit Register Setup Unit

This block is the programming front end of a 2D surface-copy engine. Software issues 32-bit method writes, each carrying a register index and a data word, into an internal register file. That file holds:

- the sizes of the source and destination surfaces;
- a 64-bit source start point and a 64-bit per-pixel step for each axis, both in 32.32 fixed point;
- the destination origin and the destination size;
- a control word holding the origin mode and the filter bit;
- an operation code.

Writing the upper word of the source-Y start is the final step of programming, and it launches the rectangle computation. For each axis the block derives the source end point from the origin mode and the destination end point from the destination origin. It clamps each end to its own surface. It then shortens each end by however far the opposite rectangle runs past its own surface.

The result is presented as one `out_valid` pulse. With it come both rectangles, the filter bit and the operation code, all of which hold until the next launch. If the operation code is not the plain copy, an `op_err` pulse appears instead. A write to an index outside the register file is dropped and flagged.

Top module: `blit_setup`

## Requirements
- R1: A write with `wr_en` high and an index below 18 stores `wr_data` at that index. The map is:
  - 0: source width; 1: source height; 2: destination surface width; 3: destination surface height.
  - 4: control, where bit 0 = 1 selects corner origin and bit 1 is the filter bit; 5: operation code.
  - 6/7: destination X/Y origin; 8/9: destination width/height.
  - 10/11 and 12/13: X and Y step, low/high word.
  - 14/15 and 16/17: X and Y source start, low/high word.
  - The reported starts `src_x0/src_y0` are the high words 15/17, and `dst_x0/dst_y0` are words 6/7.
- R2: Only a write to index 17 starts a computation. Writes to any other index never raise `out_valid` or `op_err`.
- R3: After the clock edge that samples the index-17 write, exactly one of `out_valid` or `op_err` goes high on the second following edge. It lasts one cycle.
- R4: In corner mode the source end is bits 63:32 of (start + step × destination size). The product is truncated to 64 bits, and X and Y are computed separately.
- R5: In the other mode (control bit 0 = 0) the source end is the start high word plus the destination width or height.
- R6: The destination X end is origin X + width. The destination Y end is origin Y + height.
- R7: Each end is first reduced to the smaller of itself and its own surface dimension. It is then reduced by the overshoot of the opposite rectangle's end past that rectangle's surface. An overshoot is taken as zero when the 32-bit difference is negative.
- R8: An operation code other than 0x8 (plain copy) gives `op_err` instead of `out_valid`, and the outputs keep their previous values.
- R9: A write to index 18 or above is dropped and changes no register. It raises `idx_err` for one cycle, right after the edge that samples it.
- R10: The rectangles, `out_filter` (control bit 1) and `out_op` change only together with an `out_valid` pulse.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Method write strobe |
| wr_idx | input | 5 | Register index of the write |
| wr_data | input | 32 | Write data |
| out_valid | output | 1 | One-cycle result pulse |
| op_err | output | 1 | One-cycle unsupported-operation pulse |
| idx_err | output | 1 | One-cycle out-of-range index pulse |
| src_x0 | output | 32 | Source rectangle left |
| src_y0 | output | 32 | Source rectangle top |
| src_x1 | output | 32 | Source rectangle right (clipped) |
| src_y1 | output | 32 | Source rectangle bottom (clipped) |
| dst_x0 | output | 32 | Destination rectangle left |
| dst_y0 | output | 32 | Destination rectangle top |
| dst_x1 | output | 32 | Destination rectangle right (clipped) |
| dst_y1 | output | 32 | Destination rectangle bottom (clipped) |
| out_filter | output | 1 | Filter bit of the launched copy |
| out_op | output | 32 | Operation code of the launched copy |

## Verification
A stored register word that is wrong shows up in the rectangle fields of the very next result pulse, and the clipping terms spread that error to the opposite rectangle. A broken launch decode or pipeline stage shows up as a missing or extra pulse, or a pulse in the wrong cycle, within three edges of the trigger write. A fault in the index guard shows up as a changed rectangle on the following launch, although the dropped write happened several cycles earlier. The sweep crosses both origin modes with start offsets, steps and sizes chosen so that every clamp and overshoot branch is taken on both axes.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int NUM_REGS = 18;
  localparam int IDX_W    = $clog2(NUM_REGS);

  // register indices; Y entries sit at a fixed stride from X entries
  localparam int R_SRC_W   = 0;
  localparam int R_SRC_H   = 1;
  localparam int R_DST_W   = 2;
  localparam int R_DST_H   = 3;
  localparam int R_CTRL    = 4;
  localparam int R_OP      = 5;
  localparam int R_ORG_X   = 6;
  localparam int R_ORG_Y   = 7;
  localparam int R_LEN_X   = 8;
  localparam int R_LEN_Y   = 9;
  localparam int R_STEPX_L = 10;
  localparam int R_STEPX_H = 11;
  localparam int R_SRCX_L  = 14;
  localparam int R_SRCX_H  = 15;
  localparam int R_SRCY_H  = 17;   // launch register, last in sequence

  localparam int CTRL_CORNER = 0;
  localparam int CTRL_FILT   = 1;
  localparam int AXES        = 2;
endpackage

// File: rtl/blit_regfile.sv
module blit_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 18,
  parameter int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] q [NREG],
  output logic          bad_idx
);
  logic in_range;
  assign in_range = 32'(wr_idx) < NREG;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) q[i] <= '0;
      bad_idx <= 1'b0;
    end else begin
      bad_idx <= wr_en && !in_range;
      if (wr_en && in_range) q[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/blit_axis.sv
module blit_axis #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            commit,
  input  logic            corner,
  input  logic [2*DW-1:0] src_fx,
  input  logic [2*DW-1:0] step_fx,
  input  logic [DW-1:0]   dst_org,
  input  logic [DW-1:0]   dst_len,
  input  logic [DW-1:0]   src_surf,
  input  logic [DW-1:0]   dst_surf,
  output logic [DW-1:0]   src_lo,
  output logic [DW-1:0]   src_hi,
  output logic [DW-1:0]   dst_lo,
  output logic [DW-1:0]   dst_hi
);
  localparam int FW = 2 * DW;

  logic [FW-1:0] prod;
  logic [DW-1:0] end_corner;
  logic [DW-1:0] s_start, s_end, d_start, d_end, s_lim, d_lim;
  logic [DW-1:0] over_d, over_s, cut_d, cut_s, s_clip, d_clip;

  always_comb begin
    prod       = step_fx * {{DW{1'b0}}, dst_len};
    end_corner = DW'((src_fx + prod) >> DW);
  end

  // stage 1: raw end points and snapshot of surface limits
  always_ff @(posedge clk) begin
    if (rst) begin
      s_start <= '0; s_end <= '0; d_start <= '0;
      d_end   <= '0; s_lim <= '0; d_lim   <= '0;
    end else if (load) begin
      s_start <= src_fx[FW-1:DW];
      s_end   <= corner ? end_corner : src_fx[FW-1:DW] + dst_len;
      d_start <= dst_org;
      d_end   <= dst_org + dst_len;
      s_lim   <= src_surf;
      d_lim   <= dst_surf;
    end
  end

  // stage 2: clamp and cross-overshoot trim
  always_comb begin
    over_d = d_end - d_lim;
    over_s = s_end - s_lim;
    cut_d  = over_d[DW-1] ? '0 : over_d;
    cut_s  = over_s[DW-1] ? '0 : over_s;
    s_clip = ((s_end < s_lim) ? s_end : s_lim) - cut_d;
    d_clip = ((d_end < d_lim) ? d_end : d_lim) - cut_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_lo <= '0; src_hi <= '0; dst_lo <= '0; dst_hi <= '0;
    end else if (commit) begin
      src_lo <= s_start;
      src_hi <= s_clip;
      dst_lo <= d_start;
      dst_hi <= d_clip;
    end
  end
endmodule

// File: rtl/blit_setup.sv
module blit_setup
  import blit_pkg::*;
#(
  parameter int          DW      = 32,
  parameter logic [31:0] OP_COPY = 32'h8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic             out_valid,
  output logic             op_err,
  output logic             idx_err,
  output logic [DW-1:0]    src_x0,
  output logic [DW-1:0]    src_y0,
  output logic [DW-1:0]    src_x1,
  output logic [DW-1:0]    src_y1,
  output logic [DW-1:0]    dst_x0,
  output logic [DW-1:0]    dst_y0,
  output logic [DW-1:0]    dst_x1,
  output logic [DW-1:0]    dst_y1,
  output logic             out_filter,
  output logic [DW-1:0]    out_op
);
  logic [DW-1:0] rf [NUM_REGS];
  logic          go, s1_vld, s1_ok, s1_filt;
  logic [DW-1:0] s1_op;
  logic          commit;
  logic [DW-1:0] a_slo [AXES];
  logic [DW-1:0] a_shi [AXES];
  logic [DW-1:0] a_dlo [AXES];
  logic [DW-1:0] a_dhi [AXES];

  blit_regfile #(.DW(DW), .NREG(NUM_REGS), .IW(IDX_W)) u_rf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .q(rf), .bad_idx(idx_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      go      <= 1'b0;
      s1_vld  <= 1'b0;
      s1_ok   <= 1'b0;
      s1_filt <= 1'b0;
      s1_op   <= '0;
    end else begin
      go     <= wr_en && (wr_idx == IDX_W'(R_SRCY_H));
      s1_vld <= go;
      if (go) begin
        s1_ok   <= rf[R_OP] == OP_COPY;
        s1_filt <= rf[R_CTRL][CTRL_FILT];
        s1_op   <= rf[R_OP];
      end
    end
  end

  assign commit = s1_vld && s1_ok;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    blit_axis #(.DW(DW)) u_ax (
      .clk(clk), .rst(rst), .load(go), .commit(commit),
      .corner  (rf[R_CTRL][CTRL_CORNER]),
      .src_fx  ({rf[R_SRCX_H + 2*a], rf[R_SRCX_L + 2*a]}),
      .step_fx ({rf[R_STEPX_H + 2*a], rf[R_STEPX_L + 2*a]}),
      .dst_org (rf[R_ORG_X + a]),
      .dst_len (rf[R_LEN_X + a]),
      .src_surf(rf[R_SRC_W + a]),
      .dst_surf(rf[R_DST_W + a]),
      .src_lo(a_slo[a]), .src_hi(a_shi[a]),
      .dst_lo(a_dlo[a]), .dst_hi(a_dhi[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      op_err     <= 1'b0;
      out_filter <= 1'b0;
      out_op     <= '0;
    end else begin
      out_valid <= commit;
      op_err    <= s1_vld && !s1_ok;
      if (commit) begin
        out_filter <= s1_filt;
        out_op     <= s1_op;
      end
    end
  end

  assign src_x0 = a_slo[0];
  assign src_y0 = a_slo[1];
  assign src_x1 = a_shi[0];
  assign src_y1 = a_shi[1];
  assign dst_x0 = a_dlo[0];
  assign dst_y0 = a_dlo[1];
  assign dst_x1 = a_dhi[0];
  assign dst_y1 = a_dhi[1];
endmodule

// File: rtl/blit_setup_chk.sv
module blit_setup_chk
  import blit_pkg::*;
#(
  parameter int          DW      = 32,
  parameter logic [31:0] OP_COPY = 32'h8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             out_valid,
  input logic             op_err,
  input logic             idx_err,
  input logic [DW-1:0]    src_x1,
  input logic [DW-1:0]    dst_y1,
  input logic [DW-1:0]    out_op
);
  logic trig, bad;
  assign trig = wr_en && (wr_idx == IDX_W'(R_SRCY_H));
  assign bad  = wr_en && (32'(wr_idx) >= NUM_REGS);

  a_r3_answer: assert property (@(posedge clk) disable iff (rst)
    trig |-> ##3 (out_valid || op_err));
  a_r2_cause: assert property (@(posedge clk) disable iff (rst)
    (out_valid || op_err) |-> $past(trig, 3));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && op_err));
  a_r8_op_ok: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_op == OP_COPY);
  a_r9_flag: assert property (@(posedge clk) disable iff (rst)
    bad |=> idx_err);
  a_r9_cause: assert property (@(posedge clk) disable iff (rst)
    idx_err |-> $past(bad));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(src_x1) && $stable(dst_y1) && $stable(out_op)));
endmodule

bind blit_setup blit_setup_chk #(.DW(DW), .OP_COPY(OP_COPY)) u_chk (.*);

// File: tb/blit_setup_tb.sv
module blit_setup_tb;
  localparam int CLK_NS = 10;
  localparam logic [31:0] OPC = 32'h8;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic out_valid, op_err, idx_err, out_filter;
  logic [31:0] src_x0, src_y0, src_x1, src_y1, dst_x0, dst_y0, dst_x1, dst_y1, out_op;

  int checks = 0, errors = 0, nvalid = 0, exp_valid = 0;
  bit done = 0;

  // configuration, index 0 = X, 1 = Y
  logic [63:0] c_sfx [2];
  logic [63:0] c_step[2];
  logic [31:0] c_org [2];
  logic [31:0] c_len [2];
  logic [31:0] c_ss  [2];
  logic [31:0] c_ds  [2];
  logic        c_corner, c_filt;
  logic [31:0] c_op;

  always #(CLK_NS/2) clk = ~clk;

  blit_setup u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .out_valid(out_valid), .op_err(op_err), .idx_err(idx_err),
    .src_x0(src_x0), .src_y0(src_y0), .src_x1(src_x1), .src_y1(src_y1),
    .dst_x0(dst_x0), .dst_y0(dst_y0), .dst_x1(dst_x1), .dst_y1(dst_y1),
    .out_filter(out_filter), .out_op(out_op)
  );

  always @(negedge clk) if (!rst && out_valid) nvalid++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic model(input int a, output logic [31:0] s0, s1, d0, d1);
    logic [63:0] p;
    logic [31:0] se, de, od, os, cd, cs;
    p  = c_step[a] * {32'd0, c_len[a]};
    se = c_corner ? 32'((c_sfx[a] + p) >> 32) : c_sfx[a][63:32] + c_len[a];
    de = c_org[a] + c_len[a];
    od = de - c_ds[a];  cd = od[31] ? 32'd0 : od;
    os = se - c_ss[a];  cs = os[31] ? 32'd0 : os;
    s0 = c_sfx[a][63:32];
    s1 = ((se < c_ss[a]) ? se : c_ss[a]) - cd;
    d0 = c_org[a];
    d1 = ((de < c_ds[a]) ? de : c_ds[a]) - cs;
  endtask

  // writes indices 0..16; called at a negedge
  task automatic program_regs();
    for (int a = 0; a < 2; a++) begin
      wr(0 + a, c_ss[a]);
      wr(2 + a, c_ds[a]);
    end
    wr(4, {30'd0, c_filt, c_corner});
    wr(5, c_op);
    for (int a = 0; a < 2; a++) begin
      wr(6 + a, c_org[a]);
      wr(8 + a, c_len[a]);
      wr(10 + 2*a, c_step[a][31:0]);
      wr(11 + 2*a, c_step[a][63:32]);
      wr(14 + 2*a, c_sfx[a][31:0]);
    end
    wr(15, c_sfx[0][63:32]);
  endtask

  task automatic launch_and_check();
    logic [31:0] s0, s1, d0, d1;
    chk("R2 no pulse before launch", {31'd0, out_valid | op_err}, 32'd0);
    wr(17, c_sfx[1][63:32]);
    @(negedge clk);
    chk("R3 not early", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    exp_valid++;
    chk("R3 valid", {31'd0, out_valid}, 32'd1);
    for (int a = 0; a < 2; a++) begin
      model(a, s0, s1, d0, d1);
      chk("R1 src start", a == 0 ? src_x0 : src_y0, s0);
      chk("R1 dst start", a == 0 ? dst_x0 : dst_y0, d0);
      chk(c_corner ? "R4 R7 src end" : "R5 R7 src end", a == 0 ? src_x1 : src_y1, s1);
      chk("R6 R7 dst end", a == 0 ? dst_x1 : dst_y1, d1);
    end
    chk("R10 filter", {31'd0, out_filter}, {31'd0, c_filt});
    chk("R10 op", out_op, c_op);
    @(negedge clk);
    chk("R3 single cycle", {31'd0, out_valid | op_err}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] k_sx1, k_dy1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 valid", {31'd0, out_valid}, 32'd0);
    chk("R11 err", {30'd0, op_err, idx_err}, 32'd0);
    chk("R11 rect", src_x0 | src_y0 | src_x1 | src_y1 | dst_x0 | dst_y0 | dst_x1 | dst_y1, 32'd0);
    chk("R11 op", out_op, 32'd0);

    c_ss[0] = 6; c_ss[1] = 5; c_ds[0] = 5; c_ds[1] = 6; c_op = OPC;
    for (int m = 0; m < 2; m++)
      for (int sx = 0; sx < 4; sx++)
        for (int dx = 0; dx < 4; dx++)
          for (int ln = 1; ln < 5; ln++)
            for (int st = 0; st < 3; st++) begin
              c_corner = m[0];
              c_filt   = sx[1];
              c_sfx[0] = {32'(sx), sx[0] ? 32'hC000_0000 : 32'h0};
              c_sfx[1] = {32'((sx + 1) % 4), sx[0] ? 32'h0 : 32'h4000_0000};
              c_step[0] = (st == 0) ? 64'h0000_0000_8000_0000 :
                          (st == 1) ? 64'h0000_0001_0000_0000 : 64'h0000_0002_0000_0000;
              c_step[1] = (st == 2) ? 64'h0000_0000_8000_0000 : 64'h0000_0001_8000_0000;
              c_org[0] = 32'(dx);  c_org[1] = 32'(3 - dx);
              c_len[0] = 32'(ln);  c_len[1] = 32'(6 - ln);
              program_regs();
              launch_and_check();
            end

    // R10: non-launch writes leave outputs alone
    k_sx1 = src_x1; k_dy1 = dst_y1;
    for (int i = 0; i < 17; i++) wr(i, 32'hFFFF_0000 + 32'(i));
    chk("R10 hold src", src_x1, k_sx1);
    chk("R10 hold dst", dst_y1, k_dy1);

    // R8: unsupported operation
    c_op = 32'h3; c_corner = 1'b0;
    program_regs();
    wr(17, c_sfx[1][63:32]);
    @(negedge clk); @(negedge clk);
    chk("R8 op_err", {31'd0, op_err}, 32'd1);
    chk("R8 no valid", {31'd0, out_valid}, 32'd0);
    chk("R8 outputs held", src_x1, k_sx1);
    chk("R8 op held", out_op, OPC);
    @(negedge clk);
    chk("R8 single", {31'd0, op_err}, 32'd0);

    // R9: out-of-range writes that would alias onto ctrl and source X high
    c_op = OPC; c_corner = 1'b0; c_filt = 1'b0;
    c_sfx[0] = {32'd2, 32'h0}; c_sfx[1] = {32'd1, 32'h0};
    c_org[0] = 1; c_org[1] = 2; c_len[0] = 3; c_len[1] = 2;
    program_regs();
    wr(20, 32'h3);
    chk("R9 idx_err", {31'd0, idx_err}, 32'd1);
    wr(31, 32'h0000_0100);
    chk("R9 idx_err hi", {31'd0, idx_err}, 32'd1);
    @(negedge clk);
    chk("R9 idx_err clears", {31'd0, idx_err}, 32'd0);
    launch_and_check();

    chk("R2 pulse count", 32'(nvalid), 32'(exp_valid));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule